// File: doc/BRIEF.md
# Legacy Real-Mode Memory Region Decoder

This block sits between an emulated real-mode CPU bus and the memories behind it. For each byte, word or doubleword access it takes the 20-bit starting address and selects a backing store: system RAM, an option-ROM image window, or a video-memory window. It issues a single registered request carrying a target code, a translated byte offset, byte-lane enables and the write data. Any read data coming back is merged onto the response bus.

Some address ranges are handled inside the block. A small identification area at the very top of the 1 MB space returns a fixed date string and model bytes with no memory access. When video emulation is on, the video window reads as zero and writes to it are dropped. The space just above the option-ROM limit is steered to RAM offset 0 with a one-cycle warning pulse. Any address past the end of RAM is also steered to RAM offset 0, and it sets a sticky halt flag. Region selection uses only the starting address. The remaining bytes of a wider access come from the next offsets of the same region.

Top module: `rm_region_decoder`

## Requirements
- R1: During reset the block captures `cfg_rom_limit`, and later changes to that input have no effect. A start address from 0xC0000 up to and including the captured limit targets ROM (`mem_target`=1) at offset address−0xC0000.
- R2: A start address above the captured limit and below 0xD0000 targets RAM (`mem_target`=0) at offset 0, and `warn_pulse` is high for exactly the result cycle of that access.
- R3: With `vid_emu_en` low, a start address in 0xA0000–0xBFFFF targets video memory (`mem_target`=2) at offset address−0xA0000.
- R4: With `vid_emu_en` high, an access starting in 0xA0000–0xBFFFF makes no memory request. A read there returns zero at every width.
- R5: Start addresses 0xFFFF5–0xFFFFF are served internally and make no memory request. Bytes at 0xFFFF5..0xFFFFC read as the ASCII text "08/14/99". 0xFFFFD reads 0x00, 0xFFFFE reads 0xFC, 0xFFFFF reads 0x00, and bytes past 0xFFFFF read 0x00. Writes to this area are discarded.
- R6: Any other start address at or above RAM_BYTES (default 0x80000) targets RAM offset 0 and sets `halt`. `halt` stays high until the next reset.
- R7: Every remaining start address targets RAM (`mem_target`=0) at offset equal to the address.
- R8: `req_size` 0/1/2 (3 counts as 2) selects 1/2/4 bytes, giving `mem_byte_en` 0001/0011/1111. Read data is little-endian: byte lane k of `rsp_rdata` carries the byte at start+k, and lanes that are not enabled read zero.
- R9: Results appear on the cycle after the request is sampled. While no request is in flight, and during reset, every output is zero. A write carries `req_wdata` unchanged on `mem_wdata` and sets `mem_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rom_limit | input | 20 | Last address of option-ROM window, captured in reset |
| vid_emu_en | input | 1 | Video emulation: blank the video window |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2/3 doubleword |
| req_addr | input | 20 | Starting real-mode address |
| req_wdata | input | 32 | Write data, little-endian lanes |
| mem_rdata | input | 32 | Lane data from selected store for current request |
| mem_valid | output | 1 | Request to a backing store |
| mem_write | output | 1 | Request is a write |
| mem_target | output | 2 | 0 RAM, 1 ROM, 2 video |
| mem_offset | output | 20 | Byte offset of lane 0 within the target |
| mem_byte_en | output | 4 | Active byte lanes |
| mem_wdata | output | 32 | Write data |
| rsp_valid | output | 1 | Read result on `rsp_rdata` |
| rsp_rdata | output | 32 | Read data |
| warn_pulse | output | 1 | Access fell in the gap above the ROM limit |
| halt | output | 1 | Sticky out-of-range flag |

## Verification
A wrong limit capture or region boundary shows up on the next cycle as a changed `mem_target` or `mem_offset` for an address at the window edges. The bench therefore probes both sides of each edge. A fault in the identification bytes or in the lane merge appears at once as a wrong `rsp_rdata` lane, with no memory request to hide it. A halt flag that does not stick, or that sets too early, only appears on later idle cycles, so the bench keeps comparing through those cycles and across a reset.

// File: rtl/rmd_pkg.sv
// Shared constants, region codes and the identification-byte table for the
// real-mode region decoder. Assumes a 20-bit (1 MB) address space.
package rmd_pkg;
    localparam int AW       = 20;
    localparam int ID_IDX_W = 5;

    localparam logic [AW-1:0] VID_BASE = 20'hA0000;
    localparam logic [AW-1:0] VID_LAST = 20'hBFFFF;
    localparam logic [AW-1:0] ROM_BASE = 20'hC0000;
    localparam logic [AW-1:0] GAP_END  = 20'hD0000;
    localparam logic [AW-1:0] ID_BASE  = 20'hFFFF5;

    typedef enum logic [1:0] {
        TGT_RAM = 2'd0,
        TGT_ROM = 2'd1,
        TGT_VID = 2'd2
    } tgt_e;

    typedef enum logic [2:0] {
        CLS_RAM,
        CLS_ROM,
        CLS_VID,
        CLS_VNULL,
        CLS_ID,
        CLS_GAP,
        CLS_HALT
    } cls_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_MEM,
        SRC_ID
    } src_e;

    // Byte served at index i of the identification area (index 0 = ID_BASE).
    function automatic logic [7:0] id_char(logic [ID_IDX_W-1:0] i);
        case (i)
            5'd0:    id_char = 8'h30;
            5'd1:    id_char = 8'h38;
            5'd2:    id_char = 8'h2F;
            5'd3:    id_char = 8'h31;
            5'd4:    id_char = 8'h34;
            5'd5:    id_char = 8'h2F;
            5'd6:    id_char = 8'h39;
            5'd7:    id_char = 8'h39;
            5'd9:    id_char = 8'hFC;
            default: id_char = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/rmd_classify.sv
// Start-address classifier. Picks the region for an access from its first
// byte address and computes the offset inside that region. Assumes the
// captured ROM limit is at least VID_LAST, so the gap test cannot reach
// below the ROM window.
module rmd_classify
    import rmd_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 32'h80000
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] rom_limit,
    input  logic          vid_emu_en,
    output cls_e          cls,
    output logic [AW-1:0] offset
);
    localparam logic [31:0] RAM_END = 32'(RAM_BYTES);

    // Priority-ordered region test on the start address.
    always_comb begin
        cls    = CLS_RAM;
        offset = addr;
        if (addr >= ROM_BASE && addr <= rom_limit) begin
            cls    = CLS_ROM;
            offset = addr - ROM_BASE;
        end else if (addr > rom_limit && addr < GAP_END) begin
            cls    = CLS_GAP;
            offset = '0;
        end else if (addr >= VID_BASE && addr <= VID_LAST) begin
            cls    = vid_emu_en ? CLS_VNULL : CLS_VID;
            offset = addr - VID_BASE;
        end else if (addr >= ID_BASE) begin
            cls    = CLS_ID;
            offset = addr - ID_BASE;
        end else if (32'(addr) >= RAM_END) begin
            cls    = CLS_HALT;
            offset = '0;
        end
    end
endmodule

// File: rtl/rmd_id_bytes.sv
// Identification-area byte generator. Produces one byte per lane from the
// start index; lanes run past the table end and read zero there.
module rmd_id_bytes
    import rmd_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [ID_IDX_W-1:0]  base_idx,
    output logic [8*LANES-1:0]   bytes
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // One table lookup per lane at consecutive indices.
        assign bytes[8*k +: 8] = id_char(base_idx + ID_IDX_W'(k));
    end
endmodule

// File: rtl/rmd_read_merge.sv
// Read-data merge. Chooses memory lanes, identification lanes or zero per
// lane, and zeroes lanes outside the access width.
module rmd_read_merge
    import rmd_pkg::*;
#(
    parameter int LANES = 4
) (
    input  src_e               src,
    input  logic [LANES-1:0]   lane_en,
    input  logic [8*LANES-1:0] mem_bytes,
    input  logic [8*LANES-1:0] id_bytes,
    output logic [8*LANES-1:0] rdata
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Lane select: enabled lanes take their source, others read zero.
        assign rdata[8*k +: 8] = !lane_en[k]    ? 8'h00 :
                                 (src == SRC_MEM) ? mem_bytes[8*k +: 8] :
                                 (src == SRC_ID)  ? id_bytes[8*k +: 8]  : 8'h00;
    end
endmodule

// File: rtl/rm_region_decoder.sv
// Real-mode memory region decoder top. Samples one access per cycle,
// classifies it, and drives a registered memory request and read merge on
// the following cycle. Assumes the backing store returns mem_rdata
// combinationally for the request currently on mem_*.
module rm_region_decoder
    import rmd_pkg::*;
#(
    parameter int          LANES     = 4,
    parameter int unsigned RAM_BYTES = 32'h80000,
    localparam int         DW        = 8 * LANES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_rom_limit,
    input  logic          vid_emu_en,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_size,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [1:0]    mem_target,
    output logic [AW-1:0] mem_offset,
    output logic [LANES-1:0] mem_byte_en,
    output logic [DW-1:0] mem_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          warn_pulse,
    output logic          halt
);
    localparam int SZ_MAX = $clog2(LANES);

    logic [AW-1:0]       rom_limit_q;
    cls_e                cls;
    logic [AW-1:0]       offset;
    logic                hit_mem;
    tgt_e                n_target;
    logic [LANES-1:0]    n_be;
    src_e                n_src;
    src_e                src_q;
    logic [LANES-1:0]    rd_be_q;
    logic [ID_IDX_W-1:0] id_idx_q;
    logic [DW-1:0]       id_bytes;

    rmd_classify #(.RAM_BYTES(RAM_BYTES)) u_classify (
        .addr       (req_addr),
        .rom_limit  (rom_limit_q),
        .vid_emu_en (vid_emu_en),
        .cls        (cls),
        .offset     (offset)
    );

    // Next-state request fields derived from the classified access.
    always_comb begin
        int nbytes;
        nbytes  = 1 << ((int'(req_size) > SZ_MAX) ? SZ_MAX : int'(req_size));
        for (int k = 0; k < LANES; k++) n_be[k] = (k < nbytes);
        hit_mem = req_valid && !(cls == CLS_VNULL || cls == CLS_ID);
        case (cls)
            CLS_ROM: n_target = TGT_ROM;
            CLS_VID: n_target = TGT_VID;
            default: n_target = TGT_RAM;
        endcase
        if (!req_valid || req_write) n_src = SRC_NONE;
        else if (cls == CLS_ID)      n_src = SRC_ID;
        else if (cls == CLS_VNULL)   n_src = SRC_NONE;
        else                         n_src = SRC_MEM;
    end

    // Request/response pipeline register, limit capture and sticky halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_limit_q <= cfg_rom_limit;
            mem_valid   <= 1'b0;
            mem_write   <= 1'b0;
            mem_target  <= '0;
            mem_offset  <= '0;
            mem_byte_en <= '0;
            mem_wdata   <= '0;
            rsp_valid   <= 1'b0;
            rd_be_q     <= '0;
            src_q       <= SRC_NONE;
            id_idx_q    <= '0;
            warn_pulse  <= 1'b0;
            halt        <= 1'b0;
        end else begin
            mem_valid   <= hit_mem;
            mem_write   <= hit_mem && req_write;
            mem_target  <= hit_mem ? n_target : TGT_RAM;
            mem_offset  <= hit_mem ? offset : '0;
            mem_byte_en <= hit_mem ? n_be : '0;
            mem_wdata   <= (hit_mem && req_write) ? req_wdata : '0;
            rsp_valid   <= req_valid && !req_write;
            rd_be_q     <= (req_valid && !req_write) ? n_be : '0;
            src_q       <= n_src;
            id_idx_q    <= (cls == CLS_ID) ? offset[ID_IDX_W-1:0] : '0;
            warn_pulse  <= req_valid && (cls == CLS_GAP);
            halt        <= halt || (req_valid && (cls == CLS_HALT));
        end
    end

    rmd_id_bytes #(.LANES(LANES)) u_id_bytes (
        .base_idx (id_idx_q),
        .bytes    (id_bytes)
    );

    rmd_read_merge #(.LANES(LANES)) u_merge (
        .src       (src_q),
        .lane_en   (rd_be_q),
        .mem_bytes (mem_rdata),
        .id_bytes  (id_bytes),
        .rdata     (rsp_rdata)
    );

    // Assertions guarding the pipeline outputs.
    a_r4_emu_blocks_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vid_emu_en && req_addr >= VID_BASE && req_addr <= VID_LAST)
        |=> (!mem_valid && rsp_rdata == '0));

    a_r5_id_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= ID_BASE) |=> !mem_valid);

    a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    a_r2_warn_to_ram0: assert property (@(posedge clk) disable iff (!rst_n)
        warn_pulse |-> (mem_valid && mem_target == TGT_RAM && mem_offset == '0));

    a_r1_rom_in_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_target == TGT_ROM) |-> (mem_offset <= rom_limit_q - ROM_BASE));

    a_r8_lane0_active: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_byte_en[0]);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!mem_valid && !rsp_valid && !warn_pulse));
endmodule

// File: tb/rm_region_decoder_bench.sv
`timescale 1ns/1ps
module rm_region_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cfg_rom_limit = 20'hC7FFF;
    logic        vid_emu_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] mem_rdata;
    logic        mem_valid, mem_write, rsp_valid, warn_pulse, halt;
    logic [1:0]  mem_target;
    logic [19:0] mem_offset;
    logic [3:0]  mem_byte_en;
    logic [31:0] mem_wdata, rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int lim_m;
    bit halt_m;
    string date_s = "08/14/99";

    always #2 clk = ~clk;

    rm_region_decoder u_rm_region_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_rom_limit(cfg_rom_limit),
        .vid_emu_en(vid_emu_en), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_rdata(mem_rdata), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_target(mem_target), .mem_offset(mem_offset),
        .mem_byte_en(mem_byte_en), .mem_wdata(mem_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .warn_pulse(warn_pulse), .halt(halt)
    );

    // Simple backing-store model: byte content is a function of store and offset.
    function automatic logic [7:0] pat(int t, int o);
        return 8'((o * 13) + (t * 71) + 7);
    endfunction

    always_comb begin
        for (int k = 0; k < 4; k++)
            mem_rdata[8*k +: 8] = pat(int'(mem_target), int'(mem_offset) + k);
    end

    function automatic logic [7:0] id_ref(int i);
        if (i < 8) return 8'(date_s[i]);
        if (i == 9) return 8'hFC;
        return 8'h00;
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle, predict the result from the requirements, compare.
    task automatic step(bit v, bit w, int sz, int a, logic [31:0] wd);
        string tag;
        bit    mv, ww, wn;
        int    tgt, off, n, cls;
        logic [3:0]  be;
        logic [31:0] rd;
        @(negedge clk);
        req_valid = v; req_write = w; req_size = 2'(sz);
        req_addr = 20'(a); req_wdata = wd;
        n   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        be  = (n == 1) ? 4'b0001 : (n == 2) ? 4'b0011 : 4'b1111;
        tgt = 0; off = 0; wn = 0; tag = "R9";
        if (!v)                                   cls = -1;
        else if (a >= 'hC0000 && a <= lim_m) begin cls = 1; tgt = 1; off = a - 'hC0000; tag = "R1"; end
        else if (a > lim_m && a < 'hD0000)   begin cls = 5; wn = 1; tag = "R2"; end
        else if (a >= 'hA0000 && a <= 'hBFFFF) begin
            if (vid_emu_en) begin cls = 3; tag = "R4"; end
            else begin cls = 2; tgt = 2; off = a - 'hA0000; tag = "R3"; end
        end
        else if (a >= 'hFFFF5)                begin cls = 4; off = a - 'hFFFF5; tag = "R5"; end
        else if (a >= 'h80000)                begin cls = 6; tag = "R6"; end
        else                                  begin cls = 0; off = a; tag = "R7"; end
        mv = v && (cls != 3) && (cls != 4);
        ww = mv && w;
        rd = '0;
        if (v && !w) begin
            for (int k = 0; k < n; k++) begin
                if (cls == 4)      rd[8*k +: 8] = id_ref(off + k);
                else if (cls != 3) rd[8*k +: 8] = pat(tgt, off + k);
            end
        end
        if (cls == 6) halt_m = 1;
        @(posedge clk); #1;
        check({tag, "+R8 mem"}, {mem_valid, mem_write, mem_target, mem_offset, mem_byte_en, mem_wdata},
              {mv, ww, 2'(mv ? tgt : 0), 20'(mv ? off : 0), (mv ? be : 4'b0), (ww ? wd : 32'h0)});
        check({tag, "+R8 rsp"}, {rsp_valid, rsp_rdata}, {(v && !w), rd});
        check({tag, " warn R2"}, warn_pulse, wn);
        check({tag, " halt R6"}, halt, halt_m);
    endtask

    task automatic do_reset(int lim);
        @(negedge clk);
        rst_n = 0; req_valid = 0; cfg_rom_limit = 20'(lim);
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R9 reset", {mem_valid, mem_write, mem_target, mem_offset, mem_byte_en, mem_wdata,
              rsp_valid, rsp_rdata, warn_pulse, halt}, '0);
        lim_m = lim; halt_m = 0;
        @(negedge clk); rst_n = 1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        do_reset('hC7FFF);
        // R7 RAM and R8 widths / little-endian lanes
        step(1, 0, 0, 'h01234, 0);
        step(1, 1, 1, 'h00100, 32'hA1B2C3D4);
        step(1, 0, 2, 'h7FFFC, 0);
        step(1, 0, 3, 'h00010, 0);
        step(0, 0, 0, 0, 0);
        // R1 ROM window edges, R2 gap
        step(1, 0, 0, 'hC0000, 0);
        step(1, 0, 1, 'hC7FFF, 0);
        step(1, 0, 2, 'hC8000, 0);
        step(1, 1, 2, 'hCFFFF, 32'h11223344);
        step(0, 0, 0, 0, 0);
        // R3 video window with emulation off
        step(1, 0, 2, 'hA0000, 0);
        step(1, 1, 1, 'hBFFFF, 32'h0000BEEF);
        // R4 emulation on
        vid_emu_en = 1;
        step(1, 0, 2, 'hA0000, 0);
        step(1, 1, 0, 'hBFFFF, 32'h55);
        step(1, 0, 1, 'hB1234, 0);
        step(1, 0, 2, 'h9FFFC, 0);
        vid_emu_en = 0;
        // R5 identification area
        step(1, 0, 2, 'hFFFF5, 0);
        step(1, 0, 2, 'hFFFF9, 0);
        step(1, 0, 2, 'hFFFFD, 0);
        step(1, 0, 0, 'hFFFFE, 0);
        step(1, 0, 1, 'hFFFFF, 0);
        step(1, 1, 2, 'hFFFF5, 32'hDEADBEEF);
        step(1, 0, 0, 'hFFFF4, 0);
        // R6 halt and stickiness
        step(1, 0, 0, 'h80000, 0);
        step(0, 0, 0, 0, 0);
        step(1, 0, 0, 'h00004, 0);
        step(0, 0, 0, 0, 0);
        // R1 limit captured at reset only; R6 cleared by reset
        do_reset('hC3FFF);
        @(negedge clk); cfg_rom_limit = 20'hFFFFF;
        step(1, 0, 0, 'hC3FFF, 0);
        step(1, 0, 0, 'hC4000, 0);
        step(1, 0, 0, 'hD0000, 0);
        // mixed traffic across all regions
        r = 32'h1234_5679;
        for (int i = 0; i < 300; i++) begin
            int a;
            r = r * 32'd1103515245 + 32'd12345;
            case (r[31:29])
                3'd0: a = int'(r[18:0]);
                3'd1: a = 'hA0000 + int'(r[16:0]);
                3'd2: a = 'hC0000 + int'(r[15:0]);
                3'd3: a = 'hFFFF0 + int'(r[3:0]);
                3'd4: a = 'h80000 + int'(r[17:0]);
                3'd5: a = 'hD0000 + int'(r[15:0]);
                default: a = int'(r[19:0]);
            endcase
            if (i == 150) do_reset('hCBFFF);
            vid_emu_en = r[7];
            step(r[12:11] != 0, r[8], int'(r[10:9]), a, r ^ 32'h5A5A_A5A5);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule